// File: doc/BRIEF.md
# Overclock-Tolerant Pipeline Register Stage

This block is one register stage of a pipeline whose clock is pushed past the worst-case delay of the logic feeding it. A primary register samples the stage input on the rising edge of the main clock and drives the next stage at once. A second register samples the same input on the rising edge of a delayed copy of that clock, where the delay is less than the main clock period. The delayed register gets extra settling time, so its copy is trusted.

On every main clock edge the stage compares the two copies. If they differ, or if the metastability indication for the primary register is raised, the stage records a timing error. On that same edge the input multiplexer reloads the primary register from the trusted copy, and a registered error pulse tells downstream logic that the previous word was wrong. Comparison is only armed while both registers hold valid data, so start-up and pipeline flushes never raise false errors. When the delay is zero the two clocks are the same net, and a stable input can never produce an error.

Top module: `tedr_stage`

## Requirements
- R1: On a main clock rising edge with no correction and no flush, `out_data` takes the value of `in_data` at that edge and `out_valid` takes `in_valid`.
- R2: The trusted register samples `in_data` and `in_valid` on the rising edge of `clk_shadow`. Data that settles after the main edge but before the delayed edge is therefore held only in the trusted copy.
- R3: `err` is registered on the main clock. It is high for exactly the one cycle after the edge at which a correction is taken, and low otherwise.
- R4: A correction happens at a main edge where detection is armed and the two copies differ. At that edge `out_data` is loaded with the trusted copy, `out_valid` stays high, and the `in_data` word presented at that edge is not captured.
- R5: Detection is armed only while both `out_valid` and the trusted register's valid bit are high. A mismatch or metastability indication while disarmed causes neither `err` nor a correction.
- R6: A synchronous `flush` sampled high at a main edge clears `out_valid`, forces `err` low and blocks any correction at that edge. Detection stays off until a valid word is captured again.
- R7: With `META_EN` = 1, `meta_flag` high at a main edge while detection is armed triggers exactly the same correction and error pulse as a mismatch, even when the two copies agree.
- R8: When `clk_shadow` is the same net as `clk_main` and `in_data` is stable around each edge, `err` never asserts.
- R9: While `rst_n` is low, `out_data` is zero and `out_valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main pipeline clock |
| clk_shadow | input | 1 | Same-frequency clock, rising edge delayed by less than one period |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous pipeline flush |
| in_valid | input | 1 | Stage input qualifier |
| in_data | input | DATA_W | Stage input word |
| meta_flag | input | 1 | Metastability indication for the primary register |
| out_data | output | DATA_W | Registered word to the next stage |
| out_valid | output | 1 | Qualifier for out_data |
| err | output | 1 | One-cycle timing error pulse |

## Verification
The bench creates late-arriving data by changing `in_data` between the main edge and the delayed edge. It then checks that the corrected word replaces the faulty one on the next edge and that the word offered at that edge is dropped. A design that fed the live input instead of the trusted copy would carry the wrong word forward. It also drives mismatches while the stage is disarmed: just after reset, on invalid cycles and right after a flush. A design that armed early would pulse `err` there. A stretch with the two clocks tied checks that equal copies never raise an error, and random mixes of late data, metastability hits and flushes test how the three interact.

// File: rtl/tedr_pkg.sv
package tedr_pkg;
   // Source chosen by the multiplexer in front of the primary register.
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_TRUSTED = 1'b1
   } tedr_src_e;
endpackage

// File: rtl/tedr_shadow.sv
module tedr_shadow #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_shadow,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_data,
   output logic              s_valid,
   output logic [DATA_W-1:0] s_data
);
   always_ff @(posedge clk_shadow or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= 1'b0;
         s_data  <= '0;
      end else begin
         s_valid <= d_valid;
         s_data  <= d_data;
      end
   end
endmodule

// File: rtl/tedr_detect.sv
module tedr_detect
   import tedr_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          META_EN = 1'b1
) (
   input  logic              m_valid,
   input  logic [DATA_W-1:0] m_data,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              meta_flag,
   input  logic              flush,
   output logic              fix,
   output tedr_src_e         src_sel
);
   logic              armed;
   logic [DATA_W-1:0] diff;
   logic              mismatch;
   logic              meta_hit;

   assign armed    = m_valid & s_valid;
   assign diff     = m_data ^ s_data;
   assign mismatch = |diff;

   generate
      if (META_EN) begin : g_meta
         assign meta_hit = meta_flag;
      end else begin : g_nometa
         logic unused_meta;
         assign unused_meta = meta_flag;
         assign meta_hit    = 1'b0;
      end
   endgenerate

   assign fix     = armed & ~flush & (mismatch | meta_hit);
   assign src_sel = fix ? SRC_TRUSTED : SRC_LIVE;
endmodule

// File: rtl/tedr_main.sv
module tedr_main
   import tedr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_main,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              fix,
   input  tedr_src_e         src_sel,
   output logic              m_valid,
   output logic [DATA_W-1:0] m_data,
   output logic              err_q
);
   logic [DATA_W-1:0] nxt_data;
   logic              nxt_valid;

   always_comb begin
      if (src_sel == SRC_TRUSTED) begin
         nxt_data  = s_data;
         nxt_valid = s_valid;
      end else begin
         nxt_data  = in_data;
         nxt_valid = in_valid;
      end
      if (flush) nxt_valid = 1'b0;
   end

   always_ff @(posedge clk_main or negedge rst_n) begin
      if (!rst_n) begin
         m_data  <= '0;
         m_valid <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         m_data  <= nxt_data;
         m_valid <= nxt_valid;
         err_q   <= fix;
      end
   end

   // R3: an error pulse always comes with a valid corrected word
   assert_err_has_valid_R3: assert property (@(posedge clk_main) disable iff (!rst_n)
      err_q |-> m_valid);

   // R6: a flush leaves the stage empty and silent
   assert_flush_clears_R6: assert property (@(posedge clk_main) disable iff (!rst_n)
      $past(flush) |-> (!m_valid && !err_q));
endmodule

// File: rtl/tedr_stage.sv
module tedr_stage
   import tedr_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          META_EN = 1'b1
) (
   input  logic              clk_main,
   input  logic              clk_shadow,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              meta_flag,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              err
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("tedr_stage: DATA_W must be at least 1");
      end
   endgenerate

   logic              s_valid;
   logic [DATA_W-1:0] s_data;
   logic              fix;
   tedr_src_e         src_sel;

   tedr_shadow #(.DATA_W(DATA_W)) u_shadow (
      .clk_shadow (clk_shadow),
      .rst_n      (rst_n),
      .d_valid    (in_valid),
      .d_data     (in_data),
      .s_valid    (s_valid),
      .s_data     (s_data)
   );

   tedr_detect #(.DATA_W(DATA_W), .META_EN(META_EN)) u_detect (
      .m_valid   (out_valid),
      .m_data    (out_data),
      .s_valid   (s_valid),
      .s_data    (s_data),
      .meta_flag (meta_flag),
      .flush     (flush),
      .fix       (fix),
      .src_sel   (src_sel)
   );

   tedr_main #(.DATA_W(DATA_W)) u_main (
      .clk_main (clk_main),
      .rst_n    (rst_n),
      .flush    (flush),
      .in_valid (in_valid),
      .in_data  (in_data),
      .s_valid  (s_valid),
      .s_data   (s_data),
      .fix      (fix),
      .src_sel  (src_sel),
      .m_valid  (out_valid),
      .m_data   (out_data),
      .err_q    (err)
   );

   // R4: the word shown with an error pulse is the trusted copy from before the edge
   assert_fix_uses_trusted_R4: assert property (@(posedge clk_main) disable iff (!rst_n)
      err |-> (out_data == $past(s_data)));

   // R5: no error can follow a cycle where the stage held no valid word
   assert_disarmed_silent_R5: assert property (@(posedge clk_main) disable iff (!rst_n)
      $past(!out_valid) |-> !err);

   // R5: no error can follow a cycle where the trusted copy was invalid
   assert_shadow_disarmed_R5: assert property (@(posedge clk_main) disable iff (!rst_n)
      $past(!s_valid) |-> !err);

   // R9: reset state of the outputs
   always_comb begin
      if (!rst_n) begin
         assert_reset_state_R9: assert (out_valid == 1'b0 && err == 1'b0);
      end
   end
endmodule

// File: tb/tedr_stage_bench.sv
`timescale 1ns/1ps
module tedr_stage_bench;
   localparam int unsigned W = 16;

   logic         clk_main = 1'b0;
   logic         clk_del  = 1'b0;
   logic         zero_mode = 1'b0;
   logic         clk_shadow;
   logic         rst_n = 1'b0;
   logic         flush = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         meta_flag = 1'b0;
   logic [W-1:0] out_data;
   logic         out_valid;
   logic         err;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   int cycles   = 0;

   // reference model state
   logic [W-1:0] m_data = '0, s_data = '0;
   logic         m_vld = 1'b0, s_vld = 1'b0, m_err = 1'b0;
   string        why_err = "R3";
   bit           last_flush = 1'b0, last_armed = 1'b0;

   always #2.5 clk_main = ~clk_main;
   always begin
      @(posedge clk_main); #2; clk_del = 1'b1;
      @(negedge clk_main); #2; clk_del = 1'b0;
   end
   assign clk_shadow = zero_mode ? clk_main : clk_del;

   tedr_stage #(.DATA_W(W), .META_EN(1'b1)) u_tedr_stage (
      .clk_main (clk_main), .clk_shadow (clk_shadow), .rst_n (rst_n),
      .flush (flush), .in_valid (in_valid), .in_data (in_data),
      .meta_flag (meta_flag), .out_data (out_data), .out_valid (out_valid),
      .err (err)
   );

   function automatic bit expect_fix(input bit meta, input bit fl);
      return m_vld && s_vld && !fl && ((m_data != s_data) || meta);
   endfunction

   task automatic check(input string req, input string what, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      string dreq, ereq, vreq;
      dreq = m_err ? "R2/R4" : (zero_mode ? "R8" : "R1");
      if (m_err) ereq = why_err;
      else if (last_flush) ereq = "R6";
      else if (!last_armed) ereq = "R5";
      else if (zero_mode) ereq = "R8";
      else ereq = "R3";
      vreq = last_flush ? "R6" : (m_err ? "R4" : "R1");
      check(dreq, "out_data", out_data, m_data);
      check(ereq, "err", {{(W-1){1'b0}}, err}, {{(W-1){1'b0}}, m_err});
      check(vreq, "out_valid", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, m_vld});
   endtask

   // one main cycle: check, drive, clock, then optionally make data arrive late
   task automatic step(input bit v, input logic [W-1:0] early, input logic [W-1:0] late,
                       input bit meta, input bit fl);
      bit fx;
      @(negedge clk_main);
      check_outputs();
      in_valid = v; in_data = early; meta_flag = meta; flush = fl;
      @(posedge clk_main);
      fx = expect_fix(meta, fl);
      last_flush = fl;
      last_armed = m_vld && s_vld;
      why_err = (meta && (m_data == s_data)) ? "R7" : "R3";
      m_err = fx;
      if (fx) m_data = s_data; else m_data = early;
      m_vld = fl ? 1'b0 : (fx ? s_vld : v);
      if (zero_mode) begin
         s_data = early; s_vld = v;
      end else begin
         #1 in_data = late;
         s_data = late; s_vld = v;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk_main);
      // R9: reset state
      check("R9", "out_data", out_data, '0);
      check("R9", "err", {{(W-1){1'b0}}, err}, '0);
      check("R9", "out_valid", {{(W-1){1'b0}}, out_valid}, '0);
      rst_n = 1'b1;

      // R5: invalid words with late data never arm detection
      step(1'b0, 16'h0005, 16'h0009, 1'b0, 1'b0);
      step(1'b0, 16'h0005, 16'h0005, 1'b1, 1'b0);
      // R1: clean capture, then R2/R4 late arrival corrected, R3 pulse
      step(1'b1, 16'h1111, 16'h1111, 1'b0, 1'b0);
      step(1'b1, 16'hA0A0, 16'hA0A1, 1'b0, 1'b0);
      step(1'b1, 16'h2222, 16'h2222, 1'b0, 1'b0);
      step(1'b1, 16'h3333, 16'h3333, 1'b0, 1'b0);
      // R7: metastability with equal copies
      step(1'b1, 16'h4444, 16'h4444, 1'b1, 1'b0);
      step(1'b1, 16'h5555, 16'h5555, 1'b0, 1'b0);
      // R6: flush with pending mismatch blocks correction, then disarmed cycle
      step(1'b1, 16'h6666, 16'h6667, 1'b0, 1'b0);
      step(1'b1, 16'h7777, 16'h7770, 1'b0, 1'b1);
      step(1'b1, 16'h8888, 16'h8888, 1'b0, 1'b0);
      step(1'b1, 16'h9999, 16'h9999, 1'b0, 1'b0);

      // mixed random traffic
      for (int i = 0; i < 600; i++) begin
         logic [W-1:0] e, l;
         e = W'($urandom);
         l = ($urandom % 5 == 0) ? (e ^ W'(1 << ($urandom % W))) : e;
         step(($urandom % 8) != 0, e, l, ($urandom % 17) == 0, ($urandom % 23) == 0);
      end

      // R8: zero phase shift, stable inputs
      step(1'b1, 16'h0F0F, 16'h0F0F, 1'b0, 1'b0);
      step(1'b1, 16'h0F0F, 16'h0F0F, 1'b0, 1'b0);
      zero_mode = 1'b1;
      for (int i = 0; i < 200; i++) begin
         logic [W-1:0] e;
         e = W'($urandom);
         step(($urandom % 6) != 0, e, e, 1'b0, ($urandom % 19) == 0);
      end
      @(negedge clk_main);
      check_outputs();

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   always @(posedge clk_main) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule